// File: doc/BRIEF.md
# Debug Event Qualifier for Breakpoint and Watchpoint Slots

This block sits after a bank of address comparators in a processor's self-hosted debug logic. Each comparator slot reports a raw address hit. The block then decides whether that hit becomes an architectural debug event. It checks the hit against the slot's own control fields: the privilege-access bits, the higher-mode bit, the security control and the optional link to a context comparator. It also checks the processor's present state: the current exception level, the security state, whether single-step is pending and whether the PC is aligned. One input selects whether the slots currently presented are breakpoints or watchpoints.

A slot can be chained to a context-aware breakpoint entry. The block keeps a small table of these entries, each holding an enable, a 4-bit type and a 32-bit value, and software loads them through a write port. The linked entry compares its value against one of two context-ID inputs. Which input is used depends on the entry type and on the current level. The per-slot results and their OR are registered and appear one clock after the inputs are sampled.

Top module: `dbg_event_qualifier`

## Requirements
- R1: The 2-bit security control `ssc` of a slot allows a match as follows: 0 in either state, 2 only when `secure` is 1, and 1 or 3 only when `secure` is 0.
- R2: At level 2 or 3 a match needs the slot's `hmc` bit set. At level 1 it needs `pac[0]` set. At level 0 it needs `pac[1]` set.
- R3: When `kind_wp` is 1 and `unpriv` is 1, the level check of R2 uses level 0 whatever `cur_el` is. When `kind_wp` is 0, `unpriv` has no effect.
- R4: A slot with `linked` set matches only if its link index lies in [NUM_BRPS-NUM_CTX, NUM_BRPS-1] and that entry is enabled. The entry's enable is bit 0 of the control word written through `lnk_ctrl`. Writes to indices outside that range are dropped.
- R5: An entry of type 3 selects its compare value by level. At level 3 it never matches. At level 2 it uses `ctx_id2`, but only when `host_ext` is 1, and otherwise never matches. At level 1 it uses `ctx_id1`. At level 0 it uses `ctx_id2` when both `host_ext` and `trap_gen` are 1, and `ctx_id1` otherwise. The type is taken from bits 23:20 of `lnk_ctrl`.
- R6: Type 7 compares against `ctx_id1` and type 13 against `ctx_id2`, in both cases as a full 32-bit equality with the entry value. Every other type never matches.
- R7: No slot matches while `mon_en` or `dbg_allowed` is 0.
- R8: With `kind_wp` at 0, no slot matches while `ss_active` is 1 and `ss_state` is 0. Watchpoints are not affected by this.
- R9: With `kind_wp` at 0 and `compressed` at 0, no slot matches when `pc_lo` is nonzero.
- R10: A slot whose raw hit is 0 never matches.
- R11: `slot_match_o` and `event_o` are registered one clock after their inputs, `event_o` is the OR of the slot matches, and reset clears both outputs and all link entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| kind_wp | input | 1 | 1: slots are watchpoints, 0: breakpoints |
| mon_en | input | 1 | Global monitor-debug enable |
| dbg_allowed | input | 1 | Debug exceptions currently permitted |
| ss_active | input | 1 | Single-step active |
| ss_state | input | 1 | Step state bit |
| compressed | input | 1 | Compressed-instruction mode |
| pc_lo | input | 2 | Low two PC bits |
| cur_el | input | 2 | Current exception level |
| secure | input | 1 | Secure state |
| unpriv | input | 1 | Access flagged as unprivileged |
| host_ext | input | 1 | Host-extension mode on |
| trap_gen | input | 1 | Trap-general mode on |
| ctx_id1 | input | 32 | Level-1 context ID |
| ctx_id2 | input | 32 | Level-2 context ID |
| slot_hit | input | NUM_SLOTS | Raw comparator hit per slot |
| slot_pac | input | 2*NUM_SLOTS | Privilege-access bits per slot |
| slot_hmc | input | NUM_SLOTS | Higher-mode bit per slot |
| slot_ssc | input | 2*NUM_SLOTS | Security control per slot |
| slot_linked | input | NUM_SLOTS | Linked flag per slot |
| slot_lbn | input | LBN_W*NUM_SLOTS | Linked index per slot |
| lnk_we | input | 1 | Link entry write strobe |
| lnk_idx | input | LBN_W | Link entry index to write |
| lnk_ctrl | input | 32 | Link control word (bit 0 enable, 23:20 type) |
| lnk_val | input | 32 | Link compare value |
| slot_match_o | output | NUM_SLOTS | Registered per-slot match |
| event_o | output | 1 | Registered OR of slot matches |

## Verification
The hardest case to reach from the ports is a linked match that hinges on the type-3 level selection. It needs a loaded link entry, a slot pointing at it, and a level together with host-extension and trap-general settings, all present at once. The bench gets there by writing the entry through the link port first, keeping the slot's own privilege and security fields permissive, and then changing only the level and the two mode inputs. A further step reloads the entry value so that `ctx_id1` and `ctx_id2` differ, which makes each selection outcome visible at `event_o`.

// File: rtl/dbgq_pkg.sv
package dbgq_pkg;

  typedef struct packed {
    logic        en;
    logic [3:0]  kind;
    logic [31:0] val;
  } lnk_entry_t;

  typedef enum logic [1:0] {
    CTX_NONE = 2'd0,
    CTX_ONE  = 2'd1,
    CTX_TWO  = 2'd2
  } ctx_sel_e;

  localparam logic [3:0] LT_BY_LEVEL = 4'd3;
  localparam logic [3:0] LT_CTX_ONE  = 4'd7;
  localparam logic [3:0] LT_CTX_TWO  = 4'd13;

  // security filter
  function automatic logic ssc_ok(input logic [1:0] ssc, input logic sec);
    case (ssc)
      2'd0:    return 1'b1;
      2'd2:    return sec;
      default: return !sec;
    endcase
  endfunction

  // privilege filter
  function automatic logic level_ok(input logic [1:0] el, input logic [1:0] pac,
                                    input logic hmc);
    case (el)
      2'd0:    return pac[1];
      2'd1:    return pac[0];
      default: return hmc;
    endcase
  endfunction

  // which context ID a linked entry compares against
  function automatic ctx_sel_e ctx_pick(input logic [3:0] kind, input logic [1:0] el,
                                        input logic host, input logic tge);
    case (kind)
      LT_CTX_ONE:  return CTX_ONE;
      LT_CTX_TWO:  return CTX_TWO;
      LT_BY_LEVEL: begin
        case (el)
          2'd3:    return CTX_NONE;
          2'd2:    return host ? CTX_TWO : CTX_NONE;
          2'd1:    return CTX_ONE;
          default: return (host && tge) ? CTX_TWO : CTX_ONE;
        endcase
      end
      default:     return CTX_NONE;
    endcase
  endfunction

endpackage

// File: rtl/dbgq_link_table.sv
module dbgq_link_table
  import dbgq_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_BRPS  = 6,
  parameter int NUM_CTX   = 2,
  parameter int LBN_W     = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [LBN_W-1:0]           widx,
  input  logic [31:0]                wctrl,
  input  logic [31:0]                wval,
  input  logic [NUM_SLOTS*LBN_W-1:0] lbn_i,
  input  logic [1:0]                 cur_el,
  input  logic                       host_ext,
  input  logic                       trap_gen,
  input  logic [31:0]                ctx1,
  input  logic [31:0]                ctx2,
  output logic [NUM_SLOTS-1:0]       link_ok
);

  localparam int FIRST = NUM_BRPS - NUM_CTX;

  lnk_entry_t tbl [NUM_CTX];

  for (genvar e = 0; e < NUM_CTX; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        tbl[e] <= '0;
      end else if (we && (int'(widx) == FIRST + e)) begin
        tbl[e] <= '{en: wctrl[0], kind: wctrl[23:20], val: wval};
      end
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_look
    logic [LBN_W-1:0] lbn;
    lnk_entry_t       ent;
    logic             in_rng;
    ctx_sel_e         sel;
    logic [31:0]      cmp;

    assign lbn = lbn_i[s*LBN_W +: LBN_W];

    always_comb begin
      ent    = '0;
      in_rng = 1'b0;
      for (int e = 0; e < NUM_CTX; e++) begin
        if (int'(lbn) == FIRST + e) begin
          ent    = tbl[e];
          in_rng = 1'b1;
        end
      end
      sel = ctx_pick(ent.kind, cur_el, host_ext, trap_gen);
      case (sel)
        CTX_ONE: cmp = ctx1;
        CTX_TWO: cmp = ctx2;
        default: cmp = '0;
      endcase
      link_ok[s] = in_rng && ent.en && (sel != CTX_NONE) && (cmp == ent.val);
    end
  end

endmodule

// File: rtl/dbgq_slot_qual.sv
module dbgq_slot_qual
  import dbgq_pkg::*;
(
  input  logic       hit,
  input  logic [1:0] pac,
  input  logic       hmc,
  input  logic [1:0] ssc,
  input  logic       linked,
  input  logic       link_ok,
  input  logic [1:0] eff_el,
  input  logic       secure,
  output logic       pass
);

  logic sec_pass;
  logic lvl_pass;
  logic lnk_pass;

  assign sec_pass = ssc_ok(ssc, secure);
  assign lvl_pass = level_ok(eff_el, pac, hmc);
  assign lnk_pass = !linked || link_ok;
  assign pass     = hit && sec_pass && lvl_pass && lnk_pass;

endmodule

// File: rtl/dbg_event_qualifier.sv
module dbg_event_qualifier
  import dbgq_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_BRPS  = 6,
  parameter int NUM_CTX   = 2,
  parameter int LBN_W     = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       kind_wp,
  input  logic                       mon_en,
  input  logic                       dbg_allowed,
  input  logic                       ss_active,
  input  logic                       ss_state,
  input  logic                       compressed,
  input  logic [1:0]                 pc_lo,
  input  logic [1:0]                 cur_el,
  input  logic                       secure,
  input  logic                       unpriv,
  input  logic                       host_ext,
  input  logic                       trap_gen,
  input  logic [31:0]                ctx_id1,
  input  logic [31:0]                ctx_id2,
  input  logic [NUM_SLOTS-1:0]       slot_hit,
  input  logic [2*NUM_SLOTS-1:0]     slot_pac,
  input  logic [NUM_SLOTS-1:0]       slot_hmc,
  input  logic [2*NUM_SLOTS-1:0]     slot_ssc,
  input  logic [NUM_SLOTS-1:0]       slot_linked,
  input  logic [LBN_W*NUM_SLOTS-1:0] slot_lbn,
  input  logic                       lnk_we,
  input  logic [LBN_W-1:0]           lnk_idx,
  input  logic [31:0]                lnk_ctrl,
  input  logic [31:0]                lnk_val,
  output logic [NUM_SLOTS-1:0]       slot_match_o,
  output logic                       event_o
);

  logic                 global_ok;
  logic                 step_pending;
  logic                 pc_misaligned;
  logic                 bp_block;
  logic [1:0]           eff_el;
  logic [NUM_SLOTS-1:0] link_ok;
  logic [NUM_SLOTS-1:0] slot_pass;
  logic [NUM_SLOTS-1:0] match_d;

  assign global_ok     = mon_en && dbg_allowed;
  assign step_pending  = ss_active && !ss_state;
  assign pc_misaligned = !compressed && (pc_lo != 2'b00);
  assign bp_block      = !kind_wp && (step_pending || pc_misaligned);
  assign eff_el        = (kind_wp && unpriv) ? 2'd0 : cur_el;

  dbgq_link_table #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_BRPS(NUM_BRPS), .NUM_CTX(NUM_CTX), .LBN_W(LBN_W)
  ) u_link (
    .clk(clk), .rst(rst), .we(lnk_we), .widx(lnk_idx), .wctrl(lnk_ctrl),
    .wval(lnk_val), .lbn_i(slot_lbn), .cur_el(cur_el), .host_ext(host_ext),
    .trap_gen(trap_gen), .ctx1(ctx_id1), .ctx2(ctx_id2), .link_ok(link_ok)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    dbgq_slot_qual u_q (
      .hit(slot_hit[s]), .pac(slot_pac[2*s +: 2]), .hmc(slot_hmc[s]),
      .ssc(slot_ssc[2*s +: 2]), .linked(slot_linked[s]), .link_ok(link_ok[s]),
      .eff_el(eff_el), .secure(secure), .pass(slot_pass[s])
    );
  end

  assign match_d = (global_ok && !bp_block) ? slot_pass : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_match_o <= '0;
      event_o      <= 1'b0;
    end else begin
      slot_match_o <= match_d;
      event_o      <= |match_d;
    end
  end

endmodule

// File: rtl/dbgq_checker.sv
module dbgq_checker #(
  parameter int NUM_SLOTS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 kind_wp,
  input logic                 mon_en,
  input logic                 dbg_allowed,
  input logic                 ss_active,
  input logic                 ss_state,
  input logic                 compressed,
  input logic [1:0]           pc_lo,
  input logic [NUM_SLOTS-1:0] slot_hit,
  input logic [NUM_SLOTS-1:0] slot_match_o,
  input logic                 event_o
);

  // R7
  global_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!mon_en || !dbg_allowed) |=> (slot_match_o == '0));

  // R8
  step_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (!kind_wp && ss_active && !ss_state) |=> !event_o);

  // R9
  pc_align_chk: assert property (@(posedge clk) disable iff (rst)
    (!kind_wp && !compressed && (pc_lo != 2'b00)) |=> !event_o);

  // R11
  event_or_chk: assert property (@(posedge clk) disable iff (rst)
    event_o == (|slot_match_o));

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!event_o && (slot_match_o == '0)));

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_nohit
    // R10
    no_hit_chk: assert property (@(posedge clk) disable iff (rst)
      !slot_hit[s] |=> !slot_match_o[s]);
  end

endmodule

bind dbg_event_qualifier dbgq_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk(clk), .rst(rst), .kind_wp(kind_wp), .mon_en(mon_en),
  .dbg_allowed(dbg_allowed), .ss_active(ss_active), .ss_state(ss_state),
  .compressed(compressed), .pc_lo(pc_lo), .slot_hit(slot_hit),
  .slot_match_o(slot_match_o), .event_o(event_o)
);

// File: tb/sim_dbg_event_qualifier.sv
module sim_dbg_event_qualifier;

  localparam int N  = 4;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst;
  logic kind_wp, mon_en, dbg_allowed, ss_active, ss_state, compressed;
  logic [1:0] pc_lo, cur_el;
  logic secure, unpriv, host_ext, trap_gen;
  logic [31:0] ctx_id1, ctx_id2;
  logic [N-1:0] slot_hit, slot_hmc, slot_linked;
  logic [2*N-1:0] slot_pac, slot_ssc;
  logic [LW*N-1:0] slot_lbn;
  logic lnk_we;
  logic [LW-1:0] lnk_idx;
  logic [31:0] lnk_ctrl, lnk_val;
  logic [N-1:0] slot_match_o;
  logic event_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dbg_event_qualifier #(.NUM_SLOTS(N), .NUM_BRPS(6), .NUM_CTX(2), .LBN_W(LW)) u0 (
    .clk(clk), .rst(rst), .kind_wp(kind_wp), .mon_en(mon_en),
    .dbg_allowed(dbg_allowed), .ss_active(ss_active), .ss_state(ss_state),
    .compressed(compressed), .pc_lo(pc_lo), .cur_el(cur_el), .secure(secure),
    .unpriv(unpriv), .host_ext(host_ext), .trap_gen(trap_gen),
    .ctx_id1(ctx_id1), .ctx_id2(ctx_id2), .slot_hit(slot_hit),
    .slot_pac(slot_pac), .slot_hmc(slot_hmc), .slot_ssc(slot_ssc),
    .slot_linked(slot_linked), .slot_lbn(slot_lbn), .lnk_we(lnk_we),
    .lnk_idx(lnk_idx), .lnk_ctrl(lnk_ctrl), .lnk_val(lnk_val),
    .slot_match_o(slot_match_o), .event_o(event_o)
  );

  // vector: {wp, el[1:0], sec, unpriv, pac[1:0], hmc, ssc[1:0], pad, exp}
  localparam logic [11:0] VEC [14] = '{
    {1'b0, 2'd1, 1'b0, 1'b0, 2'b01, 1'b0, 2'd0, 1'b0, 1'b1}, // R2 el1 pac0
    {1'b0, 2'd1, 1'b0, 1'b0, 2'b10, 1'b0, 2'd0, 1'b0, 1'b0}, // R2
    {1'b0, 2'd0, 1'b0, 1'b0, 2'b10, 1'b0, 2'd0, 1'b0, 1'b1}, // R2 el0 pac1
    {1'b0, 2'd2, 1'b0, 1'b0, 2'b11, 1'b0, 2'd0, 1'b0, 1'b0}, // R2 el2 no hmc
    {1'b0, 2'd2, 1'b0, 1'b0, 2'b00, 1'b1, 2'd0, 1'b0, 1'b1}, // R2 el2 hmc
    {1'b0, 2'd3, 1'b1, 1'b0, 2'b00, 1'b1, 2'd0, 1'b0, 1'b1}, // R2 el3 hmc
    {1'b0, 2'd1, 1'b1, 1'b0, 2'b01, 1'b0, 2'd1, 1'b0, 1'b0}, // R1 ssc1 sec
    {1'b0, 2'd1, 1'b1, 1'b0, 2'b01, 1'b0, 2'd2, 1'b0, 1'b1}, // R1 ssc2 sec
    {1'b0, 2'd1, 1'b0, 1'b0, 2'b01, 1'b0, 2'd2, 1'b0, 1'b0}, // R1 ssc2 ns
    {1'b0, 2'd1, 1'b0, 1'b0, 2'b01, 1'b0, 2'd3, 1'b0, 1'b1}, // R1 ssc3 ns
    {1'b1, 2'd1, 1'b0, 1'b1, 2'b01, 1'b0, 2'd0, 1'b0, 1'b0}, // R3 wp unpriv
    {1'b1, 2'd1, 1'b0, 1'b1, 2'b10, 1'b0, 2'd0, 1'b0, 1'b1}, // R3
    {1'b0, 2'd1, 1'b0, 1'b1, 2'b01, 1'b0, 2'd0, 1'b0, 1'b1}, // R3 bp ignores
    {1'b1, 2'd2, 1'b0, 1'b1, 2'b10, 1'b0, 2'd0, 1'b0, 1'b1}  // R3 el2 as el0
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [N-1:0] exp_m, input logic exp_e);
    n_chk++;
    if (slot_match_o !== exp_m || event_o !== exp_e) begin
      n_fail++;
      $display("FAIL %s: match=%b event=%b expected match=%b event=%b",
               req, slot_match_o, event_o, exp_m, exp_e);
    end
  endtask

  task automatic wr_link(input logic [LW-1:0] idx, input logic [31:0] ctrl,
                         input logic [31:0] val);
    lnk_we = 1'b1; lnk_idx = idx; lnk_ctrl = ctrl; lnk_val = val;
    tick();
    lnk_we = 1'b0;
  endtask

  task automatic defaults();
    kind_wp = 0; mon_en = 1; dbg_allowed = 1; ss_active = 0; ss_state = 0;
    compressed = 0; pc_lo = 0; cur_el = 2'd1; secure = 0; unpriv = 0;
    host_ext = 0; trap_gen = 0; ctx_id1 = 32'h1234_5678; ctx_id2 = 32'hCAFE_0002;
    slot_hit = 4'b0001; slot_pac = '1; slot_hmc = '1; slot_ssc = '0;
    slot_linked = '0; slot_lbn = '0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; lnk_we = 0; lnk_idx = 0; lnk_ctrl = 0; lnk_val = 0;
    defaults();
    tick(); tick();
    chk("R11 reset state", 4'b0000, 1'b0);
    rst = 0;

    // table walk on slot 0
    for (int i = 0; i < 14; i++) begin
      logic [11:0] v;
      v = VEC[i];
      kind_wp = v[11]; cur_el = v[10:9]; secure = v[8]; unpriv = v[7];
      slot_pac[1:0] = v[6:5]; slot_hmc[0] = v[4]; slot_ssc[1:0] = v[3:2];
      tick();
      chk($sformatf("R1/R2/R3 vector %0d", i), {3'b000, v[0]}, v[0]);
    end

    defaults();
    slot_hit = 4'b0000; tick(); chk("R10 no raw hit", 4'b0000, 1'b0);
    slot_hit = 4'b1010; tick(); chk("R11 OR of slots", 4'b1010, 1'b1);
    slot_hit = 4'b0000; #1; chk("R11 one-cycle latency", 4'b1010, 1'b1);
    tick(); chk("R11 after edge", 4'b0000, 1'b0);

    defaults();
    mon_en = 0; tick(); chk("R7 monitor enable off", 4'b0000, 1'b0);
    mon_en = 1; dbg_allowed = 0; tick(); chk("R7 debug disallowed", 4'b0000, 1'b0);

    defaults();
    ss_active = 1; tick(); chk("R8 step pending bp", 4'b0000, 1'b0);
    ss_state = 1; tick(); chk("R8 step state set", 4'b0001, 1'b1);
    ss_state = 0; kind_wp = 1; tick(); chk("R8 wp unaffected", 4'b0001, 1'b1);

    defaults();
    pc_lo = 2'd2; tick(); chk("R9 misaligned pc", 4'b0000, 1'b0);
    compressed = 1; tick(); chk("R9 compressed exempt", 4'b0001, 1'b1);
    compressed = 0; kind_wp = 1; tick(); chk("R9 wp exempt", 4'b0001, 1'b1);

    // linked entries: context range is indices 4..5
    defaults();
    slot_linked[0] = 1; slot_lbn[3:0] = 4'd4;
    wr_link(4'd4, 32'h0070_0001, 32'h1234_5678);
    wr_link(4'd3, 32'h0070_0001, 32'h1234_5678);
    tick(); chk("R6 type 7 equal", 4'b0001, 1'b1);
    ctx_id1 = 32'h9234_5678; tick(); chk("R6 full 32-bit compare", 4'b0000, 1'b0);
    ctx_id1 = 32'h1234_5678;
    slot_lbn[3:0] = 4'd3; tick(); chk("R4 index below range", 4'b0000, 1'b0);
    slot_lbn[3:0] = 4'd6; tick(); chk("R4 index above range", 4'b0000, 1'b0);
    slot_lbn[3:0] = 4'd5;
    wr_link(4'd5, 32'h00D0_0000, 32'hCAFE_0002);
    tick(); chk("R4 entry disabled", 4'b0000, 1'b0);
    wr_link(4'd5, 32'h00D0_0001, 32'hCAFE_0002);
    tick(); chk("R6 type 13", 4'b0001, 1'b1);
    wr_link(4'd5, 32'h0090_0001, 32'h1234_5678);
    tick(); chk("R6 other type", 4'b0000, 1'b0);

    // type 3 selection by level
    slot_lbn[3:0] = 4'd4;
    wr_link(4'd4, 32'h0030_0001, 32'h1234_5678);
    tick(); chk("R5 level 1 uses id1", 4'b0001, 1'b1);
    wr_link(4'd4, 32'h0030_0001, 32'hCAFE_0002);
    cur_el = 2'd2; tick(); chk("R5 level 2 no host", 4'b0000, 1'b0);
    host_ext = 1; tick(); chk("R5 level 2 host", 4'b0001, 1'b1);
    cur_el = 2'd0; trap_gen = 1; tick(); chk("R5 level 0 host+trap", 4'b0001, 1'b1);
    trap_gen = 0; tick(); chk("R5 level 0 host only", 4'b0000, 1'b0);
    cur_el = 2'd3; secure = 1; tick(); chk("R5 level 3 never", 4'b0000, 1'b0);
    secure = 0; cur_el = 2'd1; tick(); chk("R5 level 1 id1 differs", 4'b0000, 1'b0);

    // reset clears link table
    rst = 1; tick(); rst = 0;
    cur_el = 2'd2; tick(); chk("R11 reset clears entries", 4'b0000, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule